// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

After reset the block waits for a start request. On that request it captures a refresh prescaler value and a refresh timer value, then walks a memory command port through the SDRAM bring-up order. That order is one precharge of all banks, eight auto (CBR) refresh commands and one mode register write. It ends with a command that places the device in normal operation. Each command is offered with a valid strobe and stays on the port until the port answers with ready.

Once the normal command is accepted, the block raises its init-done flag and starts the refresh interval timer. A prescaler counter divides the clock by (P+1), where P is the captured prescaler value. A second counter counts T prescaler wraps, where T is the captured timer value, and emits a one-cycle refresh tick on every T-th wrap. Refresh ticks therefore repeat every T×(P+1) cycles.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While reset is held and afterwards until a start request, `cmd_valid_o`, `init_done_o` and `refresh_tick_o` are 0 and `cmd_o` is 0 (no command), even if `cmd_ready_i` is high.
- R2: The prescaler and timer values are taken from the inputs in the cycle the start request is accepted. Later changes on those inputs have no effect on the tick interval.
- R3: The first command after start is precharge-all, code 1 on `cmd_o`.
- R4: Exactly eight auto refresh commands, code 2, follow the precharge-all.
- R5: A mode register write, code 3, follows the eighth refresh.
- R6: The last command is normal operation, code 4. After it is accepted, `cmd_valid_o` stays 0.
- R7: Each command is held with `cmd_valid_o` high and `cmd_o` unchanged until a cycle in which `cmd_ready_i` is high. The next command is offered in the following cycle.
- R8: `init_done_o` goes high in the cycle the normal command is accepted and stays high until reset.
- R9: After the cycle that accepts the normal command, the first refresh tick comes T×(P+1) cycles later. Further ticks follow every T×(P+1) cycles, and each tick lasts one cycle (P = captured prescaler, T = captured timer, T ≥ 1).
- R10: No refresh tick occurs before `init_done_o` is high.
- R11: A start request while the sequence is running or after it has finished is ignored. It changes neither the command stream nor the tick interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin the bring-up sequence |
| presc_i | input | PRESC_W | Refresh prescaler value P, captured at start |
| rtimer_i | input | TIMER_W | Refresh timer value T, captured at start |
| cmd_o | output | 3 | Command code: 0 none, 1 precharge-all, 2 auto refresh, 3 mode write, 4 normal |
| cmd_valid_o | output | 1 | Command on `cmd_o` is valid |
| cmd_ready_i | input | 1 | Command port accepts the current command |
| refresh_tick_o | output | 1 | One-cycle periodic refresh request |
| init_done_o | output | 1 | Bring-up complete |

## Verification
The properties assume that reset is asserted at time zero. They also assume that `cmd_ready_i` matters only while `cmd_valid_o` is high, and that the captured timer value is nonzero, since a zero value makes the wrap compare roll over its full range. The stimulus starts every run from reset and always applies a timer value of at least 1. It drives three ready patterns: always ready, ready every third cycle, and long stalls. Start requests last one cycle, and the extra requests are issued both during the sequence and after it completes.

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq #(
  parameter int PRESC_W = 16,
  parameter int TIMER_W = 8,
  parameter int NUM_REF = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [TIMER_W-1:0] rtimer_i,
  output logic [2:0]         cmd_o,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic               refresh_tick_o,
  output logic               init_done_o
);
  localparam int CW = (NUM_REF > 1) ? $clog2(NUM_REF) : 1;
  localparam logic [CW-1:0] LAST_REF = CW'(NUM_REF - 1);
  localparam logic [TIMER_W-1:0] T_ONE = TIMER_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_PREA, S_REF, S_MRW, S_NORM, S_DONE} st_t;

  st_t                state;
  logic [CW-1:0]      ref_cnt;
  logic [PRESC_W-1:0] presc_q, pcnt;
  logic [TIMER_W-1:0] tmr_q, tcnt;

  wire accept = cmd_valid_o & cmd_ready_i;
  wire done   = (state == S_DONE);
  wire wrap   = (pcnt == presc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ref_cnt <= '0;
      presc_q <= '0;
      tmr_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          presc_q <= presc_i;
          tmr_q   <= rtimer_i;
          state   <= S_PREA;
        end
        S_PREA: if (accept) begin
          ref_cnt <= '0;
          state   <= S_REF;
        end
        S_REF: if (accept) begin
          if (ref_cnt == LAST_REF) state <= S_MRW;
          else ref_cnt <= ref_cnt + CW'(1);
        end
        S_MRW:  if (accept) state <= S_NORM;
        S_NORM: if (accept) state <= S_DONE;
        default: state <= state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !done) begin
      pcnt <= '0;
      tcnt <= '0;
    end else if (wrap) begin
      pcnt <= '0;
      tcnt <= refresh_tick_o ? '0 : tcnt + T_ONE;
    end else begin
      pcnt <= pcnt + PRESC_W'(1);
    end
  end

  always_comb begin
    case (state)
      S_PREA:  cmd_o = 3'd1;
      S_REF:   cmd_o = 3'd2;
      S_MRW:   cmd_o = 3'd3;
      S_NORM:  cmd_o = 3'd4;
      default: cmd_o = 3'd0;
    endcase
  end

  assign cmd_valid_o    = (state != S_IDLE) && !done;
  assign init_done_o    = done | ((state == S_NORM) & cmd_ready_i);
  assign refresh_tick_o = done & wrap & (tcnt == tmr_q - T_ONE);
endmodule

// File: rtl/sdram_bringup_seq_chk.sv
module sdram_bringup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cmd_o,
  input logic       cmd_valid_o,
  input logic       cmd_ready_i,
  input logic       refresh_tick_o,
  input logic       init_done_o
);
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_o)); // R7
  AST_FIRST_PREA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid_o) |-> cmd_o == 3'd1); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o); // R8
  AST_NO_CMD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> !cmd_valid_o); // R6
  AST_NO_EARLY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_tick_o |-> init_done_o); // R10
  AST_NO_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_o |-> cmd_o == 3'd0 || init_done_o); // R1
  AST_DONE_ON_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done_o) |-> cmd_valid_o && cmd_ready_i && cmd_o == 3'd4); // R8
endmodule

bind sdram_bringup_seq sdram_bringup_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i), .refresh_tick_o(refresh_tick_o),
  .init_done_o(init_done_o)
);

// File: tb/sdram_bringup_seq_tb_top.sv
module sdram_bringup_seq_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_i = 0;
  logic [15:0] presc_i = 0;
  logic [7:0]  rtimer_i = 0;
  logic [2:0]  cmd_o;
  logic        cmd_valid_o;
  logic        cmd_ready_i = 0;
  logic        refresh_tick_o;
  logic        init_done_o;

  int checks = 0, fails = 0;
  int cyc = 0;
  int rdy_mode = 0;
  int exp_period = 0;
  int ticks = 0;
  int tcount = 0;
  bit armed = 0;
  bit hold_pend = 0;
  logic [2:0] hold_cmd = 0;
  logic [2:0] expq[$];

  always #2 clk = ~clk;

  sdram_bringup_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .presc_i(presc_i),
    .rtimer_i(rtimer_i), .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i), .refresh_tick_o(refresh_tick_o),
    .init_done_o(init_done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      0: cmd_ready_i <= 1'b1;
      1: cmd_ready_i <= (cyc % 3 == 0);
      default: cmd_ready_i <= (cyc % 25 == 0);
    endcase
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  // monitor: scoreboard pop, hold check, tick timing
  always @(negedge clk) begin
    if (!rst_n) begin
      armed = 0; tcount = 0; ticks = 0; hold_pend = 0;
    end else begin
      if (hold_pend) begin
        check(cmd_valid_o && cmd_o == hold_cmd, "R7 hold", cmd_o, hold_cmd);
        hold_pend = 0;
      end
      if (cmd_valid_o && !cmd_ready_i) begin
        hold_pend = 1; hold_cmd = cmd_o;
      end
      if (armed) begin
        tcount++;
        if (refresh_tick_o) begin
          check(tcount == exp_period, "R9 tick interval", tcount, exp_period);
          tcount = 0; ticks++;
        end
        check(init_done_o, "R8 done sticky", init_done_o, 1);
      end else begin
        check(!refresh_tick_o, "R10 early tick", refresh_tick_o, 0);
      end
      if (cmd_valid_o && cmd_ready_i) begin
        if (expq.size() == 0) check(0, "R6 extra command", cmd_o, 0);
        else begin
          logic [2:0] e;
          e = expq.pop_front();
          check(cmd_o == e, "R3 R4 R5 R6 command order", cmd_o, e);
        end
        if (cmd_o == 3'd4) begin
          check(init_done_o, "R8 done on normal accept", init_done_o, 1);
          armed = 1; tcount = 0;
        end else begin
          check(!init_done_o, "R8 done early", init_done_o, 0);
        end
      end
    end
  end

  task automatic push_expected();
    expq.delete();
    expq.push_back(3'd1);                    // R3
    for (int i = 0; i < 8; i++) expq.push_back(3'd2); // R4
    expq.push_back(3'd3);                    // R5
    expq.push_back(3'd4);                    // R6
  endtask

  task automatic run(input int p, input int t, input int mode, input bit extra_start);
    rdy_mode = 1; // ready pulses even while idle
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!cmd_valid_o && cmd_o == 0 && !init_done_o && !refresh_tick_o,
          "R1 reset state", {cmd_valid_o, cmd_o, init_done_o}, 0);
    repeat (6) @(negedge clk);
    check(!cmd_valid_o && cmd_o == 0, "R1 idle no command", cmd_o, 0);
    push_expected();
    rdy_mode = mode;
    exp_period = t * (p + 1);
    @(posedge clk); #1;
    presc_i = 16'(p); rtimer_i = 8'(t); start_i = 1;
    @(posedge clk); #1;
    start_i = 0; presc_i = 16'hffff; rtimer_i = 8'd200; // R2 later changes
    if (extra_start) begin
      repeat (5) @(posedge clk);
      #1 start_i = 1;
      @(posedge clk); #1 start_i = 0; // R11 during sequence
    end
    for (int i = 0; i < 2000 && !armed; i++) @(negedge clk);
    check(armed, "R6 sequence completes", armed, 1);
    check(expq.size() == 0, "R4 command count", expq.size(), 0);
    @(posedge clk); #1 start_i = 1;
    @(posedge clk); #1 start_i = 0; // R11 after done
    repeat (exp_period * 3 + 2) @(negedge clk);
    check(!cmd_valid_o, "R11 start after done ignored", cmd_valid_o, 0);
    check(ticks >= 3, "R9 ticks seen", ticks, 3);
    check(init_done_o, "R8 still done", init_done_o, 1);
  endtask

  initial begin
    run(3, 2, 0, 0);
    run(0, 1, 1, 1);
    run(5, 3, 2, 1);
    run(2, 4, 1, 0);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule